// File: doc/BRIEF.md
# Two-Channel DC Offset Tracking Filter

This block takes two streams of 14-bit signed samples, one per channel, at the converter sample rate. For each channel it keeps a running estimate of the DC offset in a first-order leaky integrator. It can subtract that estimate from the samples, which makes the path a high-pass filter. A 4-bit code sets the integrator gain as a power of two, and so sets the corner frequency: fc = fs · 2^-(k+BASE_SHIFT) / 2π. BASE_SHIFT is 14 by default. Codes above 13 act as 13.

Two control bits choose where the correction goes. The enable bit runs the tracker and subtracts the estimate on the monitor output. The add bit also subtracts it on the main output. A freeze bit stops the tracker but still applies the held estimate. Each channel's 14-bit estimate is also brought out as a readback port.

Top module: `dccor_top`

## Requirements
- R1: Bandwidth codes 14 and 15 produce exactly the same estimate sequence as code 13.
- R2: The accumulator has F = BASE_SHIFT+13 fractional bits, where F is the number of fractional bits. When tracking, each cycle acc' = acc + ((x·2^F − acc) >>> (BASE_SHIFT+min(k,13))), where x is the current input sample and >>> is an arithmetic (flooring) shift. The estimate port equals acc >>> F, the floor of the accumulator, one cycle after the sample edge.
- R3: The two channels track independently. Each channel's estimate depends only on its own sample input.
- R4: While freeze=1 (and enable=1), the estimate does not change, and the held value is still subtracted.
- R5: When freeze goes back to 0, updates resume from the held accumulator value.
- R6: The monitor output is registered, with one cycle of latency. It equals sat(x − est) when enable=1, and x when enable=0.
- R7: The main output is registered, with one cycle of latency. It equals sat(x − est) when enable=1 and add=1, and x otherwise.
- R8: Subtraction saturates to the range [−8192, 8191] and never wraps.
- R9: Synchronous active-high reset clears the accumulators and all outputs to 0.
- R10: With enable=0 the accumulator holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| corr_en | input | 1 | Run the tracker and correct the monitor output |
| corr_add | input | 1 | Also correct the main output |
| corr_hold | input | 1 | Freeze the estimate |
| bw_code | input | 4 | Bandwidth shift code k |
| smp_in | input | NUM_CH×14 | Input samples, channel c in slice c |
| mon_out | output | NUM_CH×14 | Monitor-path samples |
| main_out | output | NUM_CH×14 | Main-path samples |
| est_out | output | NUM_CH×14 | Current DC estimate readback |

## Verification
The bench builds the block with NUM_CH=2 and BASE_SHIFT=2. This shrinks the accumulator to 29 bits, so at small codes the estimate settles within tens of cycles. As a result, full-scale estimates, saturation at both rails, and freeze and release with a visible held value can all be reached quickly. At code 13 the shift is 15, which still moves the estimate by a few counts in thirty cycles. That is enough to show that codes 13, 14 and 15 are equal and that code 12 differs from them.

// File: rtl/dccor_pkg.sv
package dccor_pkg;

    localparam int DATA_W = 14;
    localparam int K_W    = 4;
    localparam int K_MAX  = 13;

    localparam logic signed [DATA_W-1:0] S_MAX = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic signed [DATA_W-1:0] S_MIN = {1'b1, {(DATA_W-1){1'b0}}};

    typedef logic signed [DATA_W-1:0] sample_t;

    typedef struct packed {
        logic           en;
        logic           add;
        logic           frz;
        logic [K_W-1:0] k;
    } ctrl_t;

    // total right shift: base plus clamped code
    function automatic int unsigned eff_shift(logic [K_W-1:0] k, int unsigned base);
        int unsigned kc;
        kc = (int'(k) > K_MAX) ? K_MAX : int'(k);
        return base + kc;
    endfunction

    // a - b clamped to the signed sample range
    function automatic sample_t sat_sub(sample_t a, sample_t b);
        logic signed [DATA_W:0] d;
        d = {a[DATA_W-1], a} - {b[DATA_W-1], b};
        if (d > $signed({S_MAX[DATA_W-1], S_MAX}))      return S_MAX;
        else if (d < $signed({S_MIN[DATA_W-1], S_MIN})) return S_MIN;
        else                                             return d[DATA_W-1:0];
    endfunction

endpackage

// File: rtl/dccor_track.sv
module dccor_track import dccor_pkg::*; #(
    parameter int BASE_SHIFT = 14
) (
    input  logic    clk,
    input  logic    rst,
    input  ctrl_t   ctl,
    input  sample_t x,
    output sample_t est
);
    localparam int FRAC  = BASE_SHIFT + K_MAX;
    localparam int ACC_W = DATA_W + FRAC;

    logic signed [ACC_W-1:0] acc_q;
    logic signed [ACC_W:0]   x_ext, a_ext, diff, step;
    logic [ACC_W-1:0]        acc_n;
    int unsigned             sh;

    always_comb begin
        sh    = eff_shift(ctl.k, BASE_SHIFT);
        x_ext = {x[DATA_W-1], x, {FRAC{1'b0}}};
        a_ext = {acc_q[ACC_W-1], acc_q};
        diff  = x_ext - a_ext;
        step  = diff >>> sh;
        acc_n = acc_q + step[ACC_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)                     acc_q <= '0;
        else if (ctl.en && !ctl.frz) acc_q <= acc_n;
    end

    assign est = acc_q[ACC_W-1:FRAC];

    // R4: frozen tracker keeps its estimate
    p_hold_frozen_r4: assert property (@(posedge clk) disable iff (rst)
        (ctl.en && ctl.frz) |=> $stable(est));

    // R10: disabled tracker keeps its estimate
    p_hold_disabled_r10: assert property (@(posedge clk) disable iff (rst)
        (!ctl.en) |=> $stable(est));

    // R9: reset clears the estimate
    p_reset_clear_r9: assert property (@(posedge clk)
        rst |=> (est == '0));

    // R2: tracking never moves the estimate away from the input
    p_toward_up_r2: assert property (@(posedge clk) disable iff (rst)
        (ctl.en && !ctl.frz && (x > est)) |=> (est >= $past(est)));
    p_toward_dn_r2: assert property (@(posedge clk) disable iff (rst)
        (ctl.en && !ctl.frz && (x < est)) |=> (est <= $past(est)));

endmodule

// File: rtl/dccor_apply.sv
module dccor_apply import dccor_pkg::*; (
    input  logic    clk,
    input  logic    rst,
    input  ctrl_t   ctl,
    input  sample_t x,
    input  sample_t est,
    output sample_t mon,
    output sample_t out
);
    sample_t corr;

    always_comb corr = sat_sub(x, est);

    always_ff @(posedge clk) begin
        if (rst) begin
            mon <= '0;
            out <= '0;
        end else begin
            mon <= ctl.en             ? corr : x;
            out <= (ctl.en && ctl.add) ? corr : x;
        end
    end

    // R6, R7: disabled path is a one-cycle pass-through
    p_passthru_r6: assert property (@(posedge clk) disable iff (rst)
        (!ctl.en) |=> (mon == $past(x) && out == $past(x)));

    // R7: with add set both paths carry the same corrected sample
    p_main_match_r7: assert property (@(posedge clk) disable iff (rst)
        (ctl.en && ctl.add) |=> (out == mon));

    // R8: no wrap when a non-negative sample loses a non-positive estimate
    p_no_wrap_hi_r8: assert property (@(posedge clk) disable iff (rst)
        (ctl.en && x >= 0 && est <= 0) |=> (mon >= 0));
    p_no_wrap_lo_r8: assert property (@(posedge clk) disable iff (rst)
        (ctl.en && x < 0 && est >= 0) |=> (mon < 0));

endmodule

// File: rtl/dccor_top.sv
module dccor_top import dccor_pkg::*; #(
    parameter int NUM_CH     = 2,
    parameter int BASE_SHIFT = 14
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          corr_en,
    input  logic                          corr_add,
    input  logic                          corr_hold,
    input  logic [K_W-1:0]                bw_code,
    input  logic [NUM_CH-1:0][DATA_W-1:0] smp_in,
    output logic [NUM_CH-1:0][DATA_W-1:0] mon_out,
    output logic [NUM_CH-1:0][DATA_W-1:0] main_out,
    output logic [NUM_CH-1:0][DATA_W-1:0] est_out
);
    ctrl_t ctl;

    always_comb begin
        ctl.en  = corr_en;
        ctl.add = corr_add;
        ctl.frz = corr_hold;
        ctl.k   = bw_code;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        sample_t x_c, est_c, mon_c, out_c;

        assign x_c = smp_in[c];

        dccor_track #(.BASE_SHIFT(BASE_SHIFT)) i_track (
            .clk(clk), .rst(rst), .ctl(ctl), .x(x_c), .est(est_c)
        );

        dccor_apply i_apply (
            .clk(clk), .rst(rst), .ctl(ctl), .x(x_c), .est(est_c),
            .mon(mon_c), .out(out_c)
        );

        assign mon_out[c]  = mon_c;
        assign main_out[c] = out_c;
        assign est_out[c]  = est_c;
    end

endmodule

// File: tb/test_dccor_top.sv
module test_dccor_top;
    localparam int  CLK_PERIOD = 10;
    localparam int  NCH  = 2;
    localparam int  BASE = 2;
    localparam int  F    = BASE + 13;

    logic clk = 0;
    logic rst = 1;
    logic en = 0, add = 0, frz = 0;
    logic [3:0] k = 0;
    logic [NCH-1:0][13:0] smp = '0;
    logic [NCH-1:0][13:0] mon, mout, est;

    int total = 0, bad = 0;
    bit done = 0;
    longint acc_m [NCH];
    string tag;

    always #(CLK_PERIOD/2) clk = ~clk;

    dccor_top #(.NUM_CH(NCH), .BASE_SHIFT(BASE)) i_dccor_top (
        .clk(clk), .rst(rst), .corr_en(en), .corr_add(add), .corr_hold(frz),
        .bw_code(k), .smp_in(smp), .mon_out(mon), .main_out(mout), .est_out(est)
    );

    function automatic int sat14(int v);
        if (v > 8191)  return 8191;
        if (v < -8192) return -8192;
        return v;
    endfunction

    function automatic int s14(logic [13:0] v);
        return int'($signed(v));
    endfunction

    task automatic check(string t, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", t, what, act, exp);
        end
    endtask

    // one clock with model prediction and full output comparison
    task automatic cyc();
        int em [NCH];
        int eo [NCH];
        int kc;
        kc = (k > 13) ? 13 : int'(k);
        for (int c = 0; c < NCH; c++) begin
            int x, e;
            x = s14(smp[c]);
            e = int'(acc_m[c] >>> F);
            em[c] = en ? sat14(x - e) : x;
            eo[c] = (en && add) ? sat14(x - e) : x;
            if (en && !frz)
                acc_m[c] = acc_m[c] + (((longint'(x) <<< F) - acc_m[c]) >>> (BASE + kc));
        end
        @(posedge clk); #1;
        for (int c = 0; c < NCH; c++) begin
            check({tag, "/R6"}, $sformatf("mon[%0d]", c), s14(mon[c]), em[c]);
            check({tag, "/R7"}, $sformatf("main[%0d]", c), s14(mout[c]), eo[c]);
            check({tag, "/R2"}, $sformatf("est[%0d]", c), s14(est[c]), int'(acc_m[c] >>> F));
        end
    endtask

    task automatic do_reset();
        rst = 1;
        @(posedge clk); #1;
        @(posedge clk); #1;
        for (int c = 0; c < NCH; c++) acc_m[c] = 0;
        rst = 0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int held_a, held_b, r13, r15, r12;
        void'($urandom(32'h5eed));
        tag = "R9";
        do_reset();
        rst = 1;
        @(posedge clk); #1;
        for (int c = 0; c < NCH; c++) begin
            check("R9", "mon reset", s14(mon[c]), 0);
            check("R9", "main reset", s14(mout[c]), 0);
            check("R9", "est reset", s14(est[c]), 0);
        end
        rst = 0;

        // R3: independent channels converge to their own offsets
        tag = "R3";
        en = 1; add = 1; k = 0;
        smp[0] = 14'(4000); smp[1] = 14'(-3000);
        repeat (60) cyc();
        check("R3", "est a near 4000", (s14(est[0]) > 3990) ? 1 : 0, 1);
        check("R3", "est b near -3000", (s14(est[1]) < -2990) ? 1 : 0, 1);

        // R4: freeze holds the estimate but still subtracts it
        tag = "R4";
        held_a = s14(est[0]); held_b = s14(est[1]);
        frz = 1;
        smp[0] = 14'(0); smp[1] = 14'(0);
        repeat (20) cyc();
        check("R4", "held est a", s14(est[0]), held_a);
        check("R4", "held est b", s14(est[1]), held_b);
        check("R4", "mon uses held a", s14(mon[0]), -held_a);

        // R5: release resumes from the held value
        tag = "R5";
        frz = 0;
        cyc();
        check("R5", "first step a", s14(est[0]), held_a - ((held_a + 3) / 4));
        repeat (10) cyc();

        // R10: disabled tracker holds, paths pass through
        tag = "R10";
        held_a = s14(est[0]);
        en = 0;
        for (int i = 0; i < 20; i++) begin
            smp[0] = 14'($urandom); smp[1] = 14'($urandom);
            cyc();
        end
        check("R10", "est held while off", s14(est[0]), held_a);

        // R7: add off leaves main uncorrected
        tag = "R7";
        en = 1; add = 0;
        for (int i = 0; i < 20; i++) begin
            smp[0] = 14'($urandom); smp[1] = 14'($urandom);
            cyc();
        end

        // R8: saturation at both rails
        tag = "R8";
        add = 1; k = 0;
        smp[0] = 14'(8191); smp[1] = 14'(-8192);
        repeat (80) cyc();
        smp[0] = 14'(-8192); smp[1] = 14'(8191);
        cyc();
        check("R8", "low rail", s14(mon[0]), -8192);
        check("R8", "high rail", s14(mout[1]), 8191);

        // R1: codes 14 and 15 match 13, 12 differs
        tag = "R1";
        do_reset(); en = 1; add = 1; k = 13; smp[0] = 14'(5000); smp[1] = 14'(-5000);
        repeat (30) cyc();
        r13 = s14(est[0]);
        do_reset(); k = 15;
        repeat (30) cyc();
        r15 = s14(est[0]);
        check("R1", "code 15 vs 13", r15, r13);
        do_reset(); k = 14;
        repeat (30) cyc();
        check("R1", "code 14 vs 13", s14(est[0]), r13);
        do_reset(); k = 12;
        repeat (30) cyc();
        r12 = s14(est[0]);
        check("R1", "code 12 differs", (r12 != r13) ? 1 : 0, 1);

        // random mix of controls and samples
        tag = "RND";
        do_reset();
        for (int blk = 0; blk < 60; blk++) begin
            en  = ($urandom % 8) != 0;
            add = $urandom % 2;
            frz = ($urandom % 5) == 0;
            k   = (($urandom % 4) == 0) ? 4'($urandom) : 4'($urandom % 3);
            for (int i = 0; i < 50; i++) begin
                smp[0] = 14'($urandom); smp[1] = 14'(int'($urandom % 2000) - 500);
                cyc();
            end
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule